// File: doc/BRIEF.md
# Per-line GPIO interrupt detector

This block turns a set of already-filtered GPIO input lines into interrupt requests, one per line. Each line has three static configuration inputs: a detection enable, an edge/level selector and a polarity inverter. The inverter is applied before detection. A falling edge or a low level is therefore caught as a rising edge or a high level of the inverted signal.

Every line keeps a pending bit and an enable (unmask) bit. Software changes them only through a write strobe. The strobe addresses one line and carries a 4-bit command word with separate set and clear bits for pending and for enable. Each line's request output is a register that equals pending AND enable. Interrupt-controller software uses the command word to acknowledge, mask, unmask or raise a software interrupt. It can mask and acknowledge together in one write.

Top module: `gpio_irq_lines`

## Requirements
- R1: After reset, all pending, enable and request outputs are 0.
- R2: A write with `wr_en` high hits only line `wr_line`. Command bit 0 clears that line's pending bit and bit 1 sets it. When both bits are 1 the set wins.
- R3: Command bit 2 clears the addressed line's enable and bit 3 sets it. When both bits are 1 the set wins.
- R4: In edge mode (`cfg_edge`=1), pending is set at a clock edge where the detected level is 1 and was 0 at the previous clock edge. A level that stays high does not set it again after an acknowledge.
- R5: In level mode (`cfg_edge`=0), pending is set at every clock edge where the detected level is 1, so an acknowledge has no effect until the level falls.
- R6: The detected level is `line_in` XOR `cfg_invert`. With the inverter set, a falling input edge or a low input level is detected.
- R7: With `cfg_irq_en` at 0 the input never sets pending, and software writes still work.
- R8: A hardware set and a software clear at the same edge leave pending at 1.
- R9: `irq` equals pending AND enable at every edge, both updated by the same edge. A single write with bits 0 and 2 both set (mask and acknowledge) drops `irq` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NLINES | Filtered input level of each line |
| cfg_irq_en | input | NLINES | Detection enable per line |
| cfg_edge | input | NLINES | 1 = edge mode, 0 = level mode |
| cfg_invert | input | NLINES | Polarity inversion per line |
| wr_en | input | 1 | Command write strobe |
| wr_line | input | LW | Line addressed by the write |
| wr_bits | input | 4 | Command: bit0 clear pending, bit1 set pending, bit2 clear enable, bit3 set enable |
| pending | output | NLINES | Pending status per line |
| enable | output | NLINES | Enable (unmask) per line |
| irq | output | NLINES | Registered request per line |

## Verification
Directed sequences drive a held-high input in edge mode and in level mode, each followed by an acknowledge. The pending bit must stay clear in edge mode and stay set in level mode. A falling input under inversion separates the polarity path from the plain path. A same-edge rising input plus acknowledge checks the hardware-over-software priority. Random input, configuration and command traffic on all lines is compared every cycle against a bench model, which exposes cross-line write leakage and wrong set/clear precedence.

// File: rtl/gpio_irq_lines.sv
module gpio_irq_lines #(
  parameter int NLINES = 4,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic [NLINES-1:0] cfg_irq_en,
  input  logic [NLINES-1:0] cfg_edge,
  input  logic [NLINES-1:0] cfg_invert,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_line,
  input  logic [3:0]        wr_bits,
  output logic [NLINES-1:0] pending,
  output logic [NLINES-1:0] enable,
  output logic [NLINES-1:0] irq
);

  logic [NLINES-1:0] lvl, lvl_q, hw_set, hit, pend_d, ena_d;

  assign lvl = line_in ^ cfg_invert;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign hit[i]    = wr_en && (wr_line == LW'(i));
    assign hw_set[i] = cfg_irq_en[i] && (cfg_edge[i] ? (lvl[i] && !lvl_q[i]) : lvl[i]);
    assign pend_d[i] = hw_set[i] | (hit[i] & wr_bits[1]) | (pending[i] & ~(hit[i] & wr_bits[0]));
    assign ena_d[i]  = (hit[i] & wr_bits[3]) | (enable[i] & ~(hit[i] & wr_bits[2]));

    p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_irq_en[i] && cfg_edge[i] && lvl[i] && !lvl_q[i]) |=> pending[i]);

    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_irq_en[i] && !cfg_edge[i] && lvl[i]) |=> pending[i]);

    p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_irq_en[i] && !pending[i] && !(hit[i] && wr_bits[1])) |=> !pending[i]);

    p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_line == LW'(i) && wr_bits[3]) |=> enable[i]);

    p_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_line == LW'(i) && wr_bits[0] && !wr_bits[1] && !cfg_irq_en[i]) |=> !pending[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      pending <= '0;
      enable  <= '0;
      irq     <= '0;
    end else begin
      lvl_q   <= lvl;
      pending <= pend_d;
      enable  <= ena_d;
      irq     <= pend_d & ena_d;
    end
  end

  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pending & enable));

endmodule

// File: tb/test_gpio_irq_lines.sv
module test_gpio_irq_lines;
  localparam int N = 4;
  localparam int LW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] line_in = '0, cfg_irq_en = '0, cfg_edge = '0, cfg_invert = '0;
  logic wr_en = 0;
  logic [LW-1:0] wr_line = '0;
  logic [3:0] wr_bits = '0;
  logic [N-1:0] pending, enable, irq;

  int checks = 0, errors = 0;
  logic [N-1:0] m_pend = '0, m_ena = '0, m_prev = '0;

  always #5 clk = ~clk;

  gpio_irq_lines #(.NLINES(N)) i_gpio_irq_lines (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_irq_en(cfg_irq_en),
    .cfg_edge(cfg_edge), .cfg_invert(cfg_invert), .wr_en(wr_en),
    .wr_line(wr_line), .wr_bits(wr_bits), .pending(pending),
    .enable(enable), .irq(irq));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] next_pend();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic l, h, hw;
      l = line_in[i] ^ cfg_invert[i];
      h = wr_en && (wr_line == LW'(i));
      hw = cfg_irq_en[i] && (cfg_edge[i] ? (l && !m_prev[i]) : l);
      r[i] = m_pend[i];
      if (h && wr_bits[0]) r[i] = 1'b0;
      if (h && wr_bits[1]) r[i] = 1'b1;
      if (hw) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] next_ena();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic h;
      h = wr_en && (wr_line == LW'(i));
      r[i] = m_ena[i];
      if (h && wr_bits[2]) r[i] = 1'b0;
      if (h && wr_bits[3]) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic tick(input string tag);
    logic [N-1:0] np, ne;
    np = next_pend();
    ne = next_ena();
    m_prev = line_in ^ cfg_invert;
    m_pend = np;
    m_ena = ne;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 pending"}, pending, m_pend);
    chk({tag, " R3 enable"}, enable, m_ena);
    chk({tag, " R9 irq"}, irq, m_pend & m_ena);
    wr_en = 0;
    wr_bits = '0;
  endtask

  task automatic wr(input int ln, input logic [3:0] b);
    wr_en = 1;
    wr_line = LW'(ln);
    wr_bits = b;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 pending reset", pending, '0);
    chk("R1 enable reset", enable, '0);
    chk("R1 irq reset", irq, '0);

    cfg_irq_en = 4'b0111;
    cfg_edge = 4'b0101;
    cfg_invert = 4'b0100;
    line_in = 4'b0100;
    tick("R6 setup");
    chk("R6 no event at rest", pending, 4'b0000);

    line_in[0] = 1; tick("R4 rise");
    chk("R4 edge sets", pending[0], 1'b1);
    wr(0, 4'b0001); tick("R4 ack");
    chk("R4 no retrigger while high", pending[0], 1'b0);
    line_in[0] = 0; tick("R4 fall");
    chk("R4 fall ignored", pending[0], 1'b0);

    line_in[1] = 1; tick("R5 level");
    wr(1, 4'b0001); tick("R5 ack high");
    chk("R5 ack blocked while high", pending[1], 1'b1);
    line_in[1] = 0; tick("R5 drop");
    wr(1, 4'b0001); tick("R5 ack low");
    chk("R5 ack after drop", pending[1], 1'b0);

    line_in[2] = 0; tick("R6 falling");
    chk("R6 falling input detected", pending[2], 1'b1);

    line_in[3] = 1; tick("R7 toggle"); line_in[3] = 0; tick("R7 toggle");
    chk("R7 disabled line quiet", pending[3], 1'b0);
    wr(3, 4'b0010); tick("R2 sw set");
    chk("R2 sw set", pending[3], 1'b1);
    chk("R9 masked no irq", irq[3], 1'b0);
    wr(3, 4'b1000); tick("R3 unmask");
    chk("R9 irq same edge", irq[3], 1'b1);
    wr(3, 4'b0101); tick("R9 mask+ack");
    chk("R9 mask+ack drops irq", irq[3], 1'b0);
    chk("R9 mask+ack enable", enable[3], 1'b0);

    wr(2, 4'b1100); tick("R3 both");
    chk("R3 set wins", enable[2], 1'b1);
    wr(2, 4'b0011); tick("R2 both");
    chk("R2 set wins", pending[2], 1'b1);

    line_in[0] = 1; wr(0, 4'b0001); tick("R8 race");
    chk("R8 hw set beats clear", pending[0], 1'b1);

    for (int k = 0; k < 3000; k++) begin
      line_in = N'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        cfg_irq_en = N'($urandom);
        cfg_edge = N'($urandom);
        cfg_invert = N'($urandom);
      end
      if ($urandom_range(0, 2) == 0) wr(int'($urandom_range(0, N-1)), 4'($urandom));
      tick("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule